// File: doc/BRIEF.md
# Region-Tagged Translation Buffer with Overlap Purge

This block is a small fully associative address translation buffer. It holds a handful of translations. Each translation is tagged by a 24-bit region identifier and by the 3-bit region number through which it was installed. Eight region registers sit beside the buffer. The top three bits of a 64-bit virtual address pick one of them, and that register supplies the region identifier for the operation. Software-side logic fills the region registers through a simple write port. Request logic then issues one of three operations on a shared request port: a lookup for a memory reference, an insert of a new translation, or a purge of an address range.

A lookup compares the region identifier, the stored region number and the page bits above the entry's page size. One cycle after it is accepted, it answers with a hit flag, the physical address and the access rights.

Inserts and purges work on whole address ranges. Page sizes are powers of two and naturally aligned, so two ranges are either disjoint or one contains the other. Any entry with the same region identifier whose range shares a byte with the target is removed, whatever region number either side carries. An insert then writes the new entry in the same cycle. It goes to the lowest-numbered free slot, or to the slot under a wrapping replacement pointer when the buffer is full.

The control is a two-state machine. IDLE accepts requests. A lookup moves IDLE to REPLY. REPLY presents the answer for one cycle and always returns to IDLE. Inserts and purges complete in IDLE and leave the state unchanged.

Top module: `region_tlb`

## Requirements
- R1: After reset no entry is valid: every lookup misses, `op_ready` is 1 and `rsp_valid` is 0. `rsp_hit` is 0 whenever `rsp_valid` is 0.
- R2: Address bits 63:61 select region register 0 to 7. A write on `rr_we` takes effect from the next cycle, and rewriting a register changes which entries later lookups through it can hit.
- R3: A lookup is accepted when `op_valid` is 1, `op_ready` is 1 and `op_kind` is 0. Its answer appears with `rsp_valid` at 1 for exactly one cycle, in the cycle after acceptance.
- R4: A lookup hits only when all three of these hold: the entry's region identifier equals the one selected by the address, its stored region number equals address bits 63:61, and the address bits from the page size up to bit 60 match. A lookup through another region number misses even if both region registers hold the same identifier.
- R5: On a hit, `rsp_pa` takes the physical page number for bits 12 and above, except that bits below the page size come from the virtual address. `rsp_rights` returns the stored rights.
- R6: An insert (`op_kind` 1) removes every valid entry whose range overlaps the new page within the same region identifier, whatever its region number, and then writes the new entry, all in one cycle. Entries that do not overlap are kept.
- R7: A purge (`op_kind` 2) removes every entry with the selected region identifier that overlaps the given range, regardless of region number. Entries under other identifiers are kept. `op_kind` 3 has no effect.
- R8: Overlap covers mixed page sizes. A 4 KiB purge at 0x3000 removes an 8 KiB page at 0x2000, and an 8 KiB purge at 0x2000 removes a 4 KiB page at 0x3000.
- R9: An insert fills the lowest-index free entry. When no entry is free it replaces the entry under a replacement pointer, which starts at 0 and advances by one on each such replacement.
- R10: `op_psz` carries the base-2 logarithm of the page size, with 12 (4 KiB) as the smallest. A size of 61 covers the whole region.
- R11: While `op_ready` is 0, a request is ignored and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rr_we | input | 1 | Region register write enable |
| rr_sel | input | 3 | Region register to write |
| rr_rid | input | 24 | Region identifier to write |
| op_valid | input | 1 | Request present |
| op_ready | output | 1 | Request can be accepted (IDLE state) |
| op_kind | input | 2 | 0 lookup, 1 insert, 2 purge, 3 no effect |
| op_va | input | 64 | Virtual address; bits 63:61 are the region number |
| op_psz | input | 6 | Page size as log2 bytes |
| op_ppn | input | 38 | Physical page number for an insert |
| op_rights | input | 4 | Access rights for an insert |
| rsp_valid | output | 1 | Lookup answer present (REPLY state) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pa | output | 50 | Physical address on a hit |
| rsp_rights | output | 4 | Access rights on a hit |

## Verification
A stale valid bit or a wrong overlap decision can only be seen through a later lookup. Either a page that was purged still hits, or a page that should have survived misses. The bench therefore follows every insert and purge with lookups of both the removed page and its neighbours. A fault in the replacement pointer only appears once the buffer is full, on the first replacing insert. So the bench fills all entries and probes which older page disappeared after the ninth and tenth inserts. A fault in the state machine shows up within one cycle as a missing, doubled or mistimed `rsp_valid`.

// File: rtl/region_tlb_pkg.sv
package region_tlb_pkg;

    // Number of address bits that select a region register.
    localparam int VRN_W = 3;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_INSERT = 2'd1,
        OP_PURGE  = 2'd2,
        OP_NONE   = 2'd3
    } op_kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } tlb_state_e;

endpackage

// File: rtl/tlb_region_file.sv
module tlb_region_file #(
    parameter int RID_W = 24,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [RID_W-1:0] wr_rid,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [RID_W-1:0] rd_rid
);
    localparam int NREG = 1 << SEL_W;

    logic [RID_W-1:0] regs_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (wr_en) begin
            regs_q[wr_sel] <= wr_rid;
        end
    end

    assign rd_rid = regs_q[rd_sel];

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 8,
    parameter int RID_W   = 24,
    parameter int VRN_W   = 3,
    parameter int VPN_W   = 49,
    parameter int PSZ_W   = 6,
    parameter int MIN_PSZ = 12
) (
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [RID_W-1:0]   ent_rid [ENTRIES],
    input  logic [VRN_W-1:0]   ent_vrn [ENTRIES],
    input  logic [VPN_W-1:0]   ent_vpn [ENTRIES],
    input  logic [PSZ_W-1:0]   ent_psz [ENTRIES],
    input  logic [RID_W-1:0]   req_rid,
    input  logic [VRN_W-1:0]   req_vrn,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic [PSZ_W-1:0]   req_psz,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [ENTRIES-1:0] ovl_vec
);
    // Page-number bits that lie at or above a page of size 2**p.
    function automatic logic [VPN_W-1:0] span_mask(input logic [PSZ_W-1:0] p);
        int sh;
        sh = (int'(p) > MIN_PSZ) ? int'(p) - MIN_PSZ : 0;
        return (sh >= VPN_W) ? '0 : ({VPN_W{1'b1}} << sh);
    endfunction

    logic [VPN_W-1:0] req_mask;
    assign req_mask = span_mask(req_psz);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [VPN_W-1:0] diff;
        logic [VPN_W-1:0] emask;
        logic             same_rid;
        assign diff     = ent_vpn[g] ^ req_vpn;
        assign emask    = span_mask(ent_psz[g]);
        assign same_rid = ent_valid[g] && (ent_rid[g] == req_rid);
        // Lookup: identifier, region number and bits above the entry page.
        assign hit_vec[g] = same_rid && (ent_vrn[g] == req_vrn)
                            && ((diff & emask) == '0);
        // Overlap: bits above the larger of the two pages; region number ignored.
        assign ovl_vec[g] = same_rid && ((diff & emask & req_mask) == '0);
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] busy_vec,
    input  logic               take,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!busy_vec[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign victim = any_free ? free_idx : ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (take && !any_free) begin
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/region_tlb.sv
module region_tlb
    import region_tlb_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter int VA_W     = 64,
    parameter int RID_W    = 24,
    parameter int PPN_W    = 38,
    parameter int PSZ_W    = 6,
    parameter int MIN_PSZ  = 12,
    parameter int RIGHTS_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rr_we,
    input  logic [VRN_W-1:0]           rr_sel,
    input  logic [RID_W-1:0]           rr_rid,
    input  logic                       op_valid,
    output logic                       op_ready,
    input  logic [1:0]                 op_kind,
    input  logic [VA_W-1:0]            op_va,
    input  logic [PSZ_W-1:0]           op_psz,
    input  logic [PPN_W-1:0]           op_ppn,
    input  logic [RIGHTS_W-1:0]        op_rights,
    output logic                       rsp_valid,
    output logic                       rsp_hit,
    output logic [PPN_W+MIN_PSZ-1:0]   rsp_pa,
    output logic [RIGHTS_W-1:0]        rsp_rights
);
    localparam int VPN_W = VA_W - VRN_W - MIN_PSZ;
    localparam int PA_W  = PPN_W + MIN_PSZ;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // ---------------- request decode ----------------
    tlb_state_e       state_q, state_d;
    op_kind_e         kind;
    logic             accept;
    logic [VRN_W-1:0] req_vrn;
    logic [VPN_W-1:0] req_vpn;
    logic [RID_W-1:0] req_rid;

    assign kind    = op_kind_e'(op_kind);
    assign accept  = op_valid && (state_q == ST_IDLE);
    assign req_vrn = op_va[VA_W-1 -: VRN_W];
    assign req_vpn = op_va[VA_W-VRN_W-1 : MIN_PSZ];

    // ---------------- region registers ----------------
    tlb_region_file #(
        .RID_W (RID_W),
        .SEL_W (VRN_W)
    ) u_rr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (rr_we),
        .wr_sel (rr_sel),
        .wr_rid (rr_rid),
        .rd_sel (req_vrn),
        .rd_rid (req_rid)
    );

    // ---------------- entry storage ----------------
    logic [ENTRIES-1:0]  ent_valid;
    logic [RID_W-1:0]    ent_rid    [ENTRIES];
    logic [VRN_W-1:0]    ent_vrn    [ENTRIES];
    logic [VPN_W-1:0]    ent_vpn    [ENTRIES];
    logic [PSZ_W-1:0]    ent_psz    [ENTRIES];
    logic [PPN_W-1:0]    ent_ppn    [ENTRIES];
    logic [RIGHTS_W-1:0] ent_rights [ENTRIES];

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] ovl_vec;
    logic [ENTRIES-1:0] kept_vec;
    logic [IDX_W-1:0]   victim;
    logic               do_insert;
    logic               do_purge;
    logic               do_lookup;

    assign do_insert = accept && (kind == OP_INSERT);
    assign do_purge  = accept && (kind == OP_PURGE);
    assign do_lookup = accept && (kind == OP_LOOKUP);
    assign kept_vec  = ent_valid & ~ovl_vec;

    tlb_match #(
        .ENTRIES (ENTRIES),
        .RID_W   (RID_W),
        .VRN_W   (VRN_W),
        .VPN_W   (VPN_W),
        .PSZ_W   (PSZ_W),
        .MIN_PSZ (MIN_PSZ)
    ) u_match (
        .ent_valid (ent_valid),
        .ent_rid   (ent_rid),
        .ent_vrn   (ent_vrn),
        .ent_vpn   (ent_vpn),
        .ent_psz   (ent_psz),
        .req_rid   (req_rid),
        .req_vrn   (req_vrn),
        .req_vpn   (req_vpn),
        .req_psz   (op_psz),
        .hit_vec   (hit_vec),
        .ovl_vec   (ovl_vec)
    );

    tlb_victim #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_vec (kept_vec),
        .take     (do_insert),
        .victim   (victim)
    );

    // Valid bits: overlap purge and new write land in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_valid <= '0;
        end else if (do_insert) begin
            ent_valid         <= kept_vec;
            ent_valid[victim] <= 1'b1;
        end else if (do_purge) begin
            ent_valid <= kept_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (do_insert) begin
            ent_rid[victim]    <= req_rid;
            ent_vrn[victim]    <= req_vrn;
            ent_vpn[victim]    <= req_vpn;
            ent_psz[victim]    <= op_psz;
            ent_ppn[victim]    <= op_ppn;
            ent_rights[victim] <= op_rights;
        end
    end

    // ---------------- hit select and address build ----------------
    logic               hit_any;
    logic [IDX_W-1:0]   hit_idx;
    logic [PA_W-1:0]    page_base;
    logic [PA_W-1:0]    page_mask;
    logic [PA_W-1:0]    pa_calc;

    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign page_base = {ent_ppn[hit_idx], {MIN_PSZ{1'b0}}};
    assign page_mask = (int'(ent_psz[hit_idx]) >= PA_W) ? '0
                     : ({PA_W{1'b1}} << ent_psz[hit_idx]);
    assign pa_calc   = (page_base & page_mask) | (op_va[PA_W-1:0] & ~page_mask);

    // ---------------- state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (do_lookup) state_d = ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        op_ready  = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  op_ready  = 1'b1;
            ST_REPLY: rsp_valid = 1'b1;
            default:  op_ready  = 1'b0;
        endcase
    end

    // ---------------- response registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_hit    <= 1'b0;
            rsp_pa     <= '0;
            rsp_rights <= '0;
        end else if (do_lookup) begin
            rsp_hit    <= hit_any;
            rsp_pa     <= hit_any ? pa_calc : '0;
            rsp_rights <= hit_any ? ent_rights[hit_idx] : '0;
        end else begin
            rsp_hit    <= 1'b0;
        end
    end

endmodule

// File: rtl/region_tlb_chk.sv
module region_tlb_chk #(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid,
    input logic               op_ready,
    input logic [1:0]         op_kind,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [ENTRIES-1:0] ent_valid
);
    // R3
    lookup_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_kind == 2'd0) |=> rsp_valid);

    // R3
    reply_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    busy_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_ready |-> rsp_valid);

    // R1
    quiet_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit);

    // R6
    insert_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_kind == 2'd1) |=> (ent_valid != '0));

    // R7
    purge_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_kind == 2'd2)
        |=> ($countones(ent_valid) <= $past($countones(ent_valid))));

endmodule

bind region_tlb region_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .op_kind   (op_kind),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .ent_valid (ent_valid)
);

// File: tb/region_tlb_test.sv
module region_tlb_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rr_we = 1'b0;
    logic [2:0]  rr_sel = '0;
    logic [23:0] rr_rid = '0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [1:0]  op_kind = 2'd3;
    logic [63:0] op_va = '0;
    logic [5:0]  op_psz = 6'd12;
    logic [37:0] op_ppn = '0;
    logic [3:0]  op_rights = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [49:0] rsp_pa;
    logic [3:0]  rsp_rights;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          hit;
        logic [63:0] pa;
        logic [3:0]  rights;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;  // 250 MHz

    region_tlb uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rr_we      (rr_we),
        .rr_sel     (rr_sel),
        .rr_rid     (rr_rid),
        .op_valid   (op_valid),
        .op_ready   (op_ready),
        .op_kind    (op_kind),
        .op_va      (op_va),
        .op_psz     (op_psz),
        .op_ppn     (op_ppn),
        .op_rights  (op_rights),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_pa     (rsp_pa),
        .rsp_rights (rsp_rights)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor: pops one expected item per reply.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3", "unexpected reply", 64'(rsp_hit), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_hit == e.hit, e.tag, "hit", 64'(rsp_hit), 64'(e.hit));
                if (e.hit && rsp_hit) begin
                    check(64'(rsp_pa) == e.pa, e.tag, "pa", 64'(rsp_pa), e.pa);
                    check(rsp_rights == e.rights, e.tag, "rights",
                          64'(rsp_rights), 64'(e.rights));
                end
            end
        end
    end

    task automatic issue(input logic [1:0] k, input logic [2:0] vrn,
                         input logic [60:0] off, input int psz,
                         input logic [37:0] ppn, input logic [3:0] rights);
        @(negedge clk);
        op_valid  = 1'b1;
        op_kind   = k;
        op_va     = {vrn, off};
        op_psz    = 6'(psz);
        op_ppn    = ppn;
        op_rights = rights;
        @(negedge clk);
        op_valid  = 1'b0;
    endtask

    task automatic ins(input logic [2:0] vrn, input logic [60:0] off, input int psz,
                       input logic [37:0] ppn, input logic [3:0] rights);
        issue(2'd1, vrn, off, psz, ppn, rights);
    endtask

    task automatic purge(input logic [2:0] vrn, input logic [60:0] off, input int psz);
        issue(2'd2, vrn, off, psz, '0, '0);
    endtask

    task automatic look(input logic [2:0] vrn, input logic [60:0] off,
                        input bit hit, input logic [63:0] pa,
                        input logic [3:0] rights, input string tag);
        exp_t e;
        e.hit = hit; e.pa = pa; e.rights = rights; e.tag = tag;
        sb.push_back(e);
        issue(2'd0, vrn, off, 12, '0, '0);
    endtask

    task automatic set_rr(input logic [2:0] sel, input logic [23:0] rid);
        @(negedge clk);
        rr_we  = 1'b1;
        rr_sel = sel;
        rr_rid = rid;
        @(negedge clk);
        rr_we  = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(op_ready == 1'b1, "R1", "op_ready after reset", 64'(op_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;

        set_rr(3'd0, 24'h000111);
        set_rr(3'd1, 24'h000111);
        set_rr(3'd2, 24'h000222);
        set_rr(3'd3, 24'h000333);

        look(3'd0, 61'h1000, 1'b0, '0, '0, "R1 empty lookup");

        // R4 R5 R10: 8 KiB page at 0x2000
        ins(3'd0, 61'h2000, 13, 38'h80, 4'd5);
        look(3'd0, 61'h3abc, 1'b1, 64'h81abc, 4'd5, "R5 8K hit");
        look(3'd1, 61'h3abc, 1'b0, '0, '0, "R4 other region number");

        // R8: 4 KiB purge at 0x3000 via another region number removes 8 KiB page
        purge(3'd1, 61'h3000, 12);
        look(3'd0, 61'h2000, 1'b0, '0, '0, "R8 small purge of large page");

        // R8 R7: 8 KiB purge at 0x2000 removes 4 KiB page; other identifier kept
        ins(3'd0, 61'h3000, 12, 38'h91, 4'd3);
        ins(3'd2, 61'h3000, 12, 38'h92, 4'd2);
        look(3'd0, 61'h3004, 1'b1, 64'h91004, 4'd3, "R4 small page hit");
        purge(3'd0, 61'h2000, 13);
        look(3'd0, 61'h3004, 1'b0, '0, '0, "R8 large purge of small page");
        look(3'd2, 61'h3004, 1'b1, 64'h92004, 4'd2, "R7 other identifier kept");

        // R7: op_kind 3 has no effect
        issue(2'd3, 3'd2, 61'h3000, 61, '0, '0);
        look(3'd2, 61'h3004, 1'b1, 64'h92004, 4'd2, "R7 no-op kind");

        // R6: insert through another region number removes overlapped page
        ins(3'd0, 61'h5000, 12, 38'hA0, 4'd1);
        ins(3'd0, 61'h9000, 12, 38'hC0, 4'd4);
        ins(3'd1, 61'h4000, 14, 38'hB0, 4'd7);
        look(3'd0, 61'h5010, 1'b0, '0, '0, "R6 overlapped removed");
        look(3'd1, 61'h5010, 1'b1, 64'hB1010, 4'd7, "R6 new 16K hit");
        look(3'd0, 61'h9008, 1'b1, 64'hC0008, 4'd4, "R6 disjoint kept");

        // R2: rewriting a region register
        set_rr(3'd2, 24'h000999);
        look(3'd2, 61'h3004, 1'b0, '0, '0, "R2 identifier changed");
        set_rr(3'd2, 24'h000222);
        look(3'd2, 61'h3004, 1'b1, 64'h92004, 4'd2, "R2 identifier restored");

        // R11: request while busy is ignored
        begin
            exp_t e;
            e.hit = 1'b0; e.pa = '0; e.rights = '0; e.tag = "R11 first lookup";
            sb.push_back(e);
            @(negedge clk);
            op_valid = 1'b1; op_kind = 2'd0; op_va = {3'd0, 61'h7000}; op_psz = 6'd12;
            @(negedge clk);
            check(op_ready == 1'b0, "R11", "op_ready in reply", 64'(op_ready), 64'd0);
            op_kind = 2'd1; op_ppn = 38'h77; op_rights = 4'd6;
            @(negedge clk);
            op_valid = 1'b0;
        end
        look(3'd0, 61'h7000, 1'b0, '0, '0, "R11 busy insert ignored");

        // R10 R9: clear both identifiers, fill, then replace
        purge(3'd0, 61'h0, 61);
        purge(3'd2, 61'h0, 61);
        look(3'd2, 61'h3004, 1'b0, '0, '0, "R10 whole-region purge");
        look(3'd0, 61'h9008, 1'b0, '0, '0, "R10 whole-region purge");
        for (int i = 0; i < 8; i++) begin
            ins(3'd0, 61'h10000 + 61'(i) * 61'h1000, 12, 38'h100 + 38'(i), 4'(i));
        end
        for (int i = 0; i < 8; i++) begin
            look(3'd0, 61'h10010 + 61'(i) * 61'h1000, 1'b1,
                 64'h100010 + 64'(i) * 64'h1000, 4'(i), "R9 fill");
        end
        ins(3'd0, 61'h20000, 12, 38'h200, 4'd9);
        look(3'd0, 61'h10010, 1'b0, '0, '0, "R9 slot 0 replaced");
        look(3'd0, 61'h11010, 1'b1, 64'h101010, 4'd1, "R9 slot 1 kept");
        look(3'd0, 61'h20010, 1'b1, 64'h200010, 4'd9, "R9 new page");
        ins(3'd0, 61'h21000, 12, 38'h201, 4'd10);
        look(3'd0, 61'h11010, 1'b0, '0, '0, "R9 slot 1 replaced");
        look(3'd0, 61'h12010, 1'b1, 64'h102010, 4'd2, "R9 slot 2 kept");
        look(3'd0, 61'h21010, 1'b1, 64'h201010, 4'd10, "R9 second new page");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R3", "replies outstanding", 64'(sb.size()), 64'd0);
        finish_run();
    end

endmodule